// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a synchronous binary counter built from identical 4-bit slices. A slice counts up or down by one on each rising clock edge when both of its active-low enables are low. An active-low load copies a parallel data word into the count on the next edge instead. Each slice also drives an active-low terminal-count carry. That carry is gated by the slice's own T enable and depends on the count direction.

The top module chains the slices inside the block. The carry of one slice drives the T enable of the slice above it. The P enable, load and direction inputs are shared by every slice. No extra gating is needed, so a chain of N slices behaves as one 4N-bit counter. The carry of the top slice is brought out for further cascading. Registers clear asynchronously when the active-low reset is asserted. Release of the reset is synchronised to the clock inside the block.

Top module: `updn_count_chain`

## Requirements
- R1: When `load_n` is low at a rising edge, `q` equals `d` after that edge, whatever the levels of `en_p_n`, `en_t_n` and `up`.
- R2: When `load_n` is high, `en_p_n` and `en_t_n` are both low and `up` is 1, `q` grows by one at the edge and wraps from all ones to zero.
- R3: When `load_n` is high, both enables are low and `up` is 0, `q` shrinks by one at the edge and wraps from zero to all ones.
- R4: When `load_n` is high and either `en_p_n` or `en_t_n` is high, `q` keeps its value across the edge.
- R5: `carry_n` is low exactly when `en_t_n` is low and the count is at its terminal value. The terminal value is all ones with `up` = 1 and zero with `up` = 0. The carry follows `up`, `en_t_n` and the count with no clock delay.
- R6: In a chain, each slice's T enable is the carry of the slice below it. The whole `q` therefore counts as a single binary number of `NSLICE*SLICE_W` bits, and `carry_n` marks the terminal value of the whole chain.
- R7: While `rst_n` is low, `q` is zero. Counting and loading resume only after the reset release has passed through a two-flop synchroniser.
- R8: Changes on `load_n`, `en_p_n`, `en_t_n`, `up` or `d` between rising edges leave `q` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_n | input | 1 | Active-low synchronous parallel load; takes priority over counting |
| en_p_n | input | 1 | Active-low count enable shared by all slices |
| en_t_n | input | 1 | Active-low count enable of the lowest slice; also gates the carry |
| up | input | 1 | Direction select: 1 counts up, 0 counts down |
| d | input | NSLICE*SLICE_W | Parallel load data |
| q | output | NSLICE*SLICE_W | Count value |
| carry_n | output | 1 | Active-low terminal-count carry of the top slice |

## Verification
A count or load result is due one rising edge after the controls are applied. The bench drives inputs just after a falling edge and reads `q` at the next falling edge, half a period after the rising edge that updated it. The carry is combinational, so it is read 1 ns after the inputs change, against the count held before the edge. Both results are compared with an arithmetic model of a 12-bit chain and a single slice. The reset release takes two extra edges, and the bench waits them out before its first load.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
  import cnt_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p_n,
  input  logic    en_t_n,
  input  logic    up,
  output cnt_op_e op
);

  always_comb begin
    if (!load_n)                 op = OP_LOAD;
    else if (!en_p_n && !en_t_n) op = up ? OP_INC : OP_DEC;
    else                         op = OP_HOLD;
  end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         en_p_n,
  input  logic         en_t_n,
  input  logic         up,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         carry_n
);

  localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
  localparam logic [W-1:0] BOT_VAL = '0;

  cnt_op_e      op;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;
  logic         at_term;

  cnt_op_decode u_dec (
    .load_n (load_n),
    .en_p_n (en_p_n),
    .en_t_n (en_t_n),
    .up     (up),
    .op     (op)
  );

  // next-state
  always_comb begin
    cnt_ce = 1'b1;
    unique case (op)
      OP_LOAD: cnt_d = d;
      OP_INC:  cnt_d = cnt_q + W'(1);
      OP_DEC:  cnt_d = cnt_q - W'(1);
      default: begin
        cnt_d  = cnt_q;
        cnt_ce = 1'b0;
      end
    endcase
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // terminal-count carry, direction taken live
  always_comb begin
    at_term = up ? (cnt_q == TOP_VAL) : (cnt_q == BOT_VAL);
    carry_n = ~(at_term & ~en_t_n);
  end

  assign q = cnt_q;

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(d));
  a_r2_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !en_p_n && !en_t_n && up) |=> q == $past(q) + W'(1));
  a_r3_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !en_p_n && !en_t_n && !up) |=> q == $past(q) - W'(1));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && (en_p_n || en_t_n)) |=> $stable(q));
  a_r5_carry_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (!en_t_n && (q == TOP_VAL || q == BOT_VAL)));

endmodule

// File: rtl/updn_count_chain.sv
module updn_count_chain #(
  parameter int SLICE_W = 4,
  parameter int NSLICE  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_n,
  input  logic                      en_p_n,
  input  logic                      en_t_n,
  input  logic                      up,
  input  logic [NSLICE*SLICE_W-1:0] d,
  output logic [NSLICE*SLICE_W-1:0] q,
  output logic                      carry_n
);

  localparam int TOTAL_W = NSLICE * SLICE_W;

  logic              rst_sync_n;
  logic [NSLICE:0]   t_chain;
  logic [TOTAL_W-1:0] q_all;

  cnt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign t_chain[0] = en_t_n;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    cnt_stage #(.W(SLICE_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load_n  (load_n),
      .en_p_n  (en_p_n),
      .en_t_n  (t_chain[i]),
      .up      (up),
      .d       (d[i*SLICE_W +: SLICE_W]),
      .q       (q_all[i*SLICE_W +: SLICE_W]),
      .carry_n (t_chain[i+1])
    );

    if (i > 0) begin : g_link
      a_r6_upper_waits: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (load_n && t_chain[i]) |=> $stable(q_all[i*SLICE_W +: SLICE_W]));
    end
  end

  assign q       = q_all;
  assign carry_n = t_chain[NSLICE];

  a_r7_reset_clear: assert property (@(posedge clk)
    !rst_sync_n |-> q_all == '0);

endmodule

// File: tb/tb_updn_count_chain.sv
module tb_updn_count_chain;

  localparam int W  = 4;
  localparam int NS = 3;
  localparam int TW = W * NS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_n, en_p_n, en_t_n, up;
  logic [TW-1:0] d;
  logic [TW-1:0] q;
  logic [W-1:0]  q1;
  logic          carry_n, carry1_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int ref12, ref4;

  always #4 clk = ~clk;

  updn_count_chain #(.SLICE_W(W), .NSLICE(NS)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p_n(en_p_n),
    .en_t_n(en_t_n), .up(up), .d(d), .q(q), .carry_n(carry_n));

  updn_count_chain #(.SLICE_W(W), .NSLICE(1)) dut1 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p_n(en_p_n),
    .en_t_n(en_t_n), .up(up), .d(d[W-1:0]), .q(q1), .carry_n(carry1_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int exp_carry(input int v, input int maxv);
    if (en_t_n) return 1;
    if (up) return (v == maxv) ? 0 : 1;
    return (v == 0) ? 0 : 1;
  endfunction

  function automatic int next_val(input int v, input int dv, input int mask);
    if (!load_n) return dv & mask;
    if (!en_p_n && !en_t_n) return up ? ((v + 1) & mask) : ((v - 1) & mask);
    return v;
  endfunction

  // called just after a falling edge with inputs already set
  task automatic step(input string tag);
    #1;
    chk({tag, " carry 12b (R5)"}, int'(carry_n), exp_carry(ref12, 4095));
    chk({tag, " carry 4b (R5)"}, int'(carry1_n), exp_carry(ref4, 15));
    @(posedge clk);
    ref12 = next_val(ref12, int'(d), 4095);
    ref4  = next_val(ref4, int'(d[W-1:0]), 15);
    @(negedge clk);
    chk({tag, " q 12b (R6)"}, int'(q), ref12);
    chk({tag, " q 4b"}, int'(q1), ref4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b1; up = 1'b1; d = '0;
    ref12 = 0; ref4 = 0;
    #3;
    chk("R7 reset q 12b", int'(q), 0);
    chk("R7 reset q 4b", int'(q1), 0);
    @(negedge clk);
    en_p_n = 1'b0; en_t_n = 1'b0;   // would count if reset were not held
    @(negedge clk);
    chk("R7 held in reset", int'(q), 0);
    en_p_n = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 after release", int'(q), 0);

    // R1: load with enables off and with counting requested
    load_n = 1'b0; d = 12'h5A3; en_p_n = 1'b1; en_t_n = 1'b1; up = 1'b0;
    step("R1 load idle");
    d = 12'h0C7; en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1;
    step("R1 load priority");

    // R2: count up across the 12-bit wrap
    d = 12'hFF0; step("R2 preset");
    load_n = 1'b1; up = 1'b1;
    for (int i = 0; i < 40; i++) step("R2 up");

    // R3: count down across zero
    load_n = 1'b0; d = 12'h010; step("R3 preset");
    load_n = 1'b1; up = 1'b0;
    for (int i = 0; i < 40; i++) step("R3 down");

    // R4: either enable high holds
    en_p_n = 1'b1; en_t_n = 1'b0;
    for (int i = 0; i < 5; i++) step("R4 P high");
    en_p_n = 1'b0; en_t_n = 1'b1;
    for (int i = 0; i < 5; i++) step("R4 T high");

    // R5: carry follows direction with no clock
    load_n = 1'b0; d = 12'hFFF; en_p_n = 1'b1; en_t_n = 1'b1; step("R5 preset max");
    load_n = 1'b1; en_t_n = 1'b0; up = 1'b1; #1;
    chk("R5 max up", int'(carry_n), 0);
    up = 1'b0; #1;
    chk("R5 max down", int'(carry_n), 1);
    en_t_n = 1'b1; up = 1'b1; #1;
    chk("R5 T high masks", int'(carry_n), 1);
    @(negedge clk);
    load_n = 1'b0; d = 12'h000; step("R5 preset zero");
    load_n = 1'b1; en_t_n = 1'b0; up = 1'b0; #1;
    chk("R5 zero down", int'(carry_n), 0);
    up = 1'b1; #1;
    chk("R5 zero up", int'(carry_n), 1);
    @(negedge clk);

    // R8: toggling controls between edges leaves q alone
    en_p_n = 1'b1; en_t_n = 1'b1; load_n = 1'b1;
    @(posedge clk); #1;
    load_n = 1'b0; d = 12'hABC; #1;
    up = 1'b0; en_p_n = 1'b0; en_t_n = 1'b0; #1;
    chk("R8 mid-cycle q 12b", int'(q), ref12);
    chk("R8 mid-cycle q 4b", int'(q1), ref4);
    load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b1;
    @(negedge clk);
    chk("R8 after edge", int'(q), ref12);

    // R6: full sweeps of the 12-bit chain in both directions
    load_n = 1'b0; d = '0; step("R6 preset");
    load_n = 1'b1; en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1;
    for (int i = 0; i < 4100; i++) step("R6 up sweep");
    up = 1'b0;
    for (int i = 0; i < 4100; i++) step("R6 down sweep");

    finish_run();
  end

endmodule